// File: doc/BRIEF.md
# Operand addressing sequencer

This block is the control and operand-delivery slice of a 16-bit two-operand processor core. It fetches one instruction word per instruction and decodes the source and destination addressing fields. It then walks a small state machine through the extension-word fetches, operand reads, the execute step and the result store that the encoding needs. Any step an instruction does not need is skipped, so every addressing path has a fixed and predictable cycle cost.

A single 16-bit memory port carries all traffic, with one access per cycle. Instruction words, extension words and operand reads use it, and so do result and stack writes. Read data is expected combinationally in the same cycle. The register file (R0 acts as the program counter, R1 as the stack pointer, R2 as the status/absolute base and R3 as a constant source) and the constant generator sit inside the block. The execute step is reduced to a move or an add. The block reports the end of every instruction with a one-cycle `done` pulse and the number of cycles that instruction took.

States: FETCH (instruction read, decode, and execute/store for register-to-register work), SRC_EXT (source extension word), SRC_RD (source operand read), DST_EXT (destination extension word), DST_RD (old destination read), DST_WR (result write), PUSH_WR (stack write) and JUMP (target load). Transitions: FETCH goes to JUMP for a jump. For an indexed, absolute or symbolic source it goes to SRC_EXT, and for an indirect, auto-increment or immediate source it goes to SRC_RD. Otherwise it goes to PUSH_WR for a push, to DST_EXT for an indexed destination, and else back to FETCH. SRC_EXT goes to SRC_RD. SRC_RD goes to PUSH_WR, DST_EXT or FETCH by the same rule. DST_EXT goes to DST_RD and then to DST_WR. DST_WR, PUSH_WR and JUMP return to FETCH.

Top module: `opseq_core`

## Requirements
- R1: Encodings. Two-operand word: bits 15:12 opcode (4 = move, 5 = add), 11:8 source register, 7 destination mode (0 register, 1 indexed), 6 byte flag, 5:4 source mode (0 register, 1 indexed, 2 indirect, 3 auto-increment), 3:0 destination register. Push: bits 15:7 = 000100100, 6 byte flag, 5:4 source mode, 3:0 source register. Jump: bits 15:13 = 001, bits 9:0 a signed word offset, and the target is the address after the jump word plus twice the offset.
- R2: A register source or a constant source adds no cycle. R3 gives 0, 1, 2 and 0xFFFF for modes 0 to 3, and R2 gives 4 for mode 2 and 8 for mode 3. None of these touches memory.
- R3: An indirect, auto-increment or immediate (R0 auto-increment) source adds one cycle. Auto-increment raises the register by 1 for byte operations and by 2 for word operations, but always by 2 for R0 and R1.
- R4: An indexed source adds two cycles and reads the operand at base plus extension word. The base is the register for R4 to R15, the address of the extension word itself for R0 (symbolic), and zero for R2 (absolute).
- R5: An indexed, symbolic or absolute destination adds three cycles: extension word, old-value read, and result write. The write happens in the last cycle of the instruction.
- R6: A source extension word is read before a destination extension word, and the program counter advances by 2 for every word fetched.
- R7: Byte and word forms take the same cycles. A byte operand is the high byte at an odd address and the low byte at an even one. A byte result is zero-extended into registers, and it is written to memory on the addressed lane only (byte enable 01 for even, 10 for odd). Word accesses ignore address bit 0.
- R8: Push costs one cycle plus the source cost plus one. It lowers R1 by 2 and writes the operand at the new R1.
- R9: Any jump takes exactly two cycles.
- R10: `done` is high for one cycle after the last cycle of each instruction. `cycles` then holds that instruction's cycle count.
- R11: Reset clears all registers, puts the program counter at RESET_PC and starts in FETCH, reading that address.
- R12: The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address of the current access |
| mem_rd | output | 1 | Read access this cycle |
| mem_wr | output | 1 | Write access this cycle |
| mem_be | output | 2 | Byte lanes written (bit 0 low byte) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| done | output | 1 | One-cycle end-of-instruction pulse |
| cycles | output | CNT_W | Cycle count of the instruction just ended |

## Verification
The assertions assume that the memory returns read data in the same cycle as the request, and that only the move, add, push and jump encodings are ever fetched. They also assume that no auto-increment register is the destination register of the same instruction and that R0 is never a register-mode operand or destination. The random program generator keeps to these limits. It takes data and pointer registers from R4 to R11 only, keeps pointers and the stack inside a data region separate from code, and never lets jumps leave the program.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    localparam int DW      = 16;
    localparam int REG_W   = 4;
    localparam int NREG    = 1 << REG_W;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_SRC_EXT,
        ST_SRC_RD,
        ST_DST_EXT,
        ST_DST_RD,
        ST_DST_WR,
        ST_PUSH_WR,
        ST_JUMP
    } seq_state_e;

    function automatic logic is_jump(input logic [DW-1:0] w);
        return w[15:13] == 3'b001;
    endfunction

    function automatic logic is_push(input logic [DW-1:0] w);
        return w[15:7] == 9'b000100100;
    endfunction

endpackage

// File: rtl/opseq_regfile.sv
module opseq_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we_a,
    input  logic [AW-1:0] wa_a,
    input  logic [DW-1:0] wd_a,
    input  logic          we_b,
    input  logic [AW-1:0] wa_b,
    input  logic [DW-1:0] wd_b
);

    logic [DW-1:0] regs [NREG];

    // port b has priority when both ports hit the same entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (we_b && wa_b == AW'(i))
                    regs[i] <= wd_b;
                else if (we_a && wa_a == AW'(i))
                    regs[i] <= wd_a;
            end
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/opseq_constgen.sv
module opseq_constgen #(
    parameter int DW = 16
) (
    input  logic [3:0]    reg_sel,
    input  logic [1:0]    mode,
    output logic          hit,
    output logic [DW-1:0] value
);

    always_comb begin
        hit   = 1'b0;
        value = '0;
        if (reg_sel == 4'd3) begin
            hit = 1'b1;
            unique case (mode)
                2'd0: value = DW'(0);
                2'd1: value = DW'(1);
                2'd2: value = DW'(2);
                2'd3: value = '1;
            endcase
        end else if (reg_sel == 4'd2 && mode[1]) begin
            hit   = 1'b1;
            value = mode[0] ? DW'(8) : DW'(4);
        end
    end

endmodule

// File: rtl/opseq_core.sv
module opseq_core
    import opseq_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0100,
    parameter int          CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [15:0]      mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [1:0]       mem_be,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic             done,
    output logic [CNT_W-1:0] cycles
);

    seq_state_e       state_q, state_d;
    logic [DW-1:0]    pc_q, ir_q, ea_q, src_q, dst_q;
    logic [CNT_W-1:0] cnt_q, cycles_q;
    logic             done_q;

    // decode: the fetch cycle decodes straight from the bus
    logic [DW-1:0]    ins;
    logic [3:0]       opc, src_r, dst_r;
    logic [1:0]       as_m;
    logic             bw, ad, jmp, push;

    assign ins   = (state_q == ST_FETCH) ? mem_rdata : ir_q;
    assign opc   = ins[15:12];
    assign push  = is_push(ins);
    assign jmp   = is_jump(ins);
    assign src_r = push ? ins[3:0] : ins[11:8];
    assign dst_r = ins[3:0];
    assign ad    = ins[7] & ~push;
    assign bw    = ins[6];
    assign as_m  = ins[5:4];

    logic          c_hit;
    logic [DW-1:0] c_val;

    opseq_constgen #(.DW(DW)) u_cgen (
        .reg_sel (src_r),
        .mode    (as_m),
        .hit     (c_hit),
        .value   (c_val)
    );

    logic [REG_W-1:0] rf_ra_b, rf_wa_a;
    logic [DW-1:0]    rf_a, rf_b, rf_wd_a, rf_wd_b;
    logic             rf_we_a, rf_we_b;

    assign rf_ra_b = push ? REG_W'(1) : dst_r;

    opseq_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (src_r),
        .ra_b  (rf_ra_b),
        .rd_a  (rf_a),
        .rd_b  (rf_b),
        .we_a  (rf_we_a),
        .wa_a  (rf_wa_a),
        .wd_a  (rf_wd_a),
        .we_b  (rf_we_b),
        .wa_b  (dst_r),
        .wd_b  (rf_wd_b)
    );

    // operand selection
    logic          src_mem, fin, imm_src;
    logic [DW-1:0] src_reg, src_xbase, dst_reg, dst_xbase, src_addr;
    logic [DW-1:0] src_mem_val, src_now, dst_now, sum, res;

    function automatic logic [DW-1:0] lane(input logic [DW-1:0] a,
                                           input logic [DW-1:0] d,
                                           input logic          b);
        if (!b)   return d;
        if (a[0]) return {8'h00, d[15:8]};
        return {8'h00, d[7:0]};
    endfunction

    assign src_mem     = ~c_hit & (as_m != 2'd0);
    assign imm_src     = (src_r == 4'd0) & (as_m == 2'd3);
    assign src_reg     = (src_r == 4'd0) ? pc_q : rf_a;
    assign src_xbase   = (src_r == 4'd2) ? '0 : src_reg;
    assign dst_reg     = (dst_r == 4'd0) ? pc_q : rf_b;
    assign dst_xbase   = (dst_r == 4'd2) ? '0 : dst_reg;
    assign src_addr    = (as_m == 2'd1) ? ea_q : src_reg;
    assign src_mem_val = lane(src_addr, mem_rdata, bw);

    always_comb begin
        if (state_q == ST_SRC_RD) src_now = src_mem_val;
        else if (src_mem)         src_now = src_q;
        else if (c_hit)           src_now = c_val;
        else                      src_now = src_reg;
    end

    assign dst_now = ad ? dst_q : dst_reg;
    assign sum     = (opc == 4'h5 && !push) ? src_now + dst_now : src_now;
    assign res     = bw ? {8'h00, sum[7:0]} : sum;

    // next-state logic
    function automatic seq_state_e after_src(input logic p, input logic a);
        if (p) return ST_PUSH_WR;
        if (a) return ST_DST_EXT;
        return ST_FETCH;
    endfunction

    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH: begin
                if (jmp)          state_d = ST_JUMP;
                else if (src_mem) state_d = (as_m == 2'd1) ? ST_SRC_EXT : ST_SRC_RD;
                else              state_d = after_src(push, ad);
            end
            ST_SRC_EXT: state_d = ST_SRC_RD;
            ST_SRC_RD:  state_d = after_src(push, ad);
            ST_DST_EXT: state_d = ST_DST_RD;
            ST_DST_RD:  state_d = ST_DST_WR;
            ST_DST_WR,
            ST_PUSH_WR,
            ST_JUMP:    state_d = ST_FETCH;
        endcase
    end

    assign fin = (state_d == ST_FETCH);

    // memory port and register-write controls
    always_comb begin
        mem_addr  = pc_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = bw ? {res[7:0], res[7:0]} : res;
        rf_we_a   = 1'b0;
        rf_wa_a   = src_r;
        rf_wd_a   = src_reg + ((bw && src_r != 4'd1) ? DW'(1) : DW'(2));
        rf_we_b   = 1'b0;
        rf_wd_b   = res;
        unique case (state_q)
            ST_FETCH, ST_SRC_EXT, ST_DST_EXT: mem_rd = 1'b1;
            ST_SRC_RD: begin
                mem_rd   = 1'b1;
                mem_addr = src_addr;
                rf_we_a  = (as_m == 2'd3) && !imm_src;
            end
            ST_DST_RD: begin
                mem_rd   = 1'b1;
                mem_addr = ea_q;
            end
            ST_DST_WR: begin
                mem_wr   = 1'b1;
                mem_addr = ea_q;
            end
            ST_PUSH_WR: begin
                mem_wr   = 1'b1;
                mem_addr = rf_b - DW'(2);
                rf_we_a  = 1'b1;
                rf_wa_a  = REG_W'(1);
                rf_wd_a  = rf_b - DW'(2);
            end
            ST_JUMP: mem_rd = 1'b0;
        endcase
        if (fin && (state_q == ST_FETCH || state_q == ST_SRC_RD) && dst_r != 4'd0)
            rf_we_b = 1'b1;
        mem_be = !bw ? 2'b11 : (mem_addr[0] ? 2'b10 : 2'b01);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            ir_q     <= '0;
            ea_q     <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            cycles_q <= '0;
            done_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + DW'(2);
                end
                ST_SRC_EXT: begin
                    ea_q <= src_xbase + mem_rdata;
                    pc_q <= pc_q + DW'(2);
                end
                ST_SRC_RD: begin
                    src_q <= src_mem_val;
                    if (imm_src) pc_q <= pc_q + DW'(2);
                end
                ST_DST_EXT: begin
                    ea_q <= dst_xbase + mem_rdata;
                    pc_q <= pc_q + DW'(2);
                end
                ST_DST_RD: dst_q <= lane(ea_q, mem_rdata, bw);
                ST_JUMP:   pc_q  <= pc_q + {{5{ir_q[9]}}, ir_q[9:0], 1'b0};
                ST_DST_WR, ST_PUSH_WR: ;
            endcase
            done_q <= fin;
            if (fin) begin
                cycles_q <= cnt_q + CNT_W'(1);
                cnt_q    <= '0;
            end else begin
                cnt_q    <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign done   = done_q;
    assign cycles = cycles_q;

endmodule

// File: rtl/opseq_core_chk.sv
module opseq_core_chk
    import opseq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [1:0]       mem_be,
    input logic             done,
    input logic [CNT_W-1:0] cycles,
    input seq_state_e       state
);

    // R12
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    cycle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CNT_W'(1) && cycles <= CNT_W'(6)));

    // R5
    write_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> done);

    // R9
    jump_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JUMP) |=> (done && cycles == CNT_W'(2)));

    // R7
    lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_be != 2'b00));

    // R11
    reset_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (state == ST_FETCH && mem_rd));

endmodule

bind opseq_core opseq_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .mem_be (mem_be),
    .done   (done),
    .cycles (cycles),
    .state  (state_q)
);

// File: tb/sim_opseq_core.sv
module sim_opseq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, done;
    logic [1:0]  mem_be;
    logic [2:0]  cycles;

    always #10 clk = ~clk;

    opseq_core #(.RESET_PC(16'h0100), .CNT_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .cycles(cycles)
    );

    // memory seen by the design
    logic [15:0] mem [0:1023];
    assign mem_rdata = mem[mem_addr[10:1]];
    always @(posedge clk) begin
        if (mem_wr) begin
            if (mem_be[0]) mem[mem_addr[10:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[10:1]][15:8] <= mem_wdata[15:8];
        end
    end

    int n_chk = 0, n_err = 0, n_both = 0, tick = 0, n_instr = 0;
    bit timed_out = 0;

    always @(posedge clk) begin
        tick++;
        if (tick > 50000) timed_out = 1;
    end
    always @(negedge clk) if (rst_n && mem_rd && mem_wr) n_both++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] mm [0:1023];
    logic [15:0] mr [0:15];
    logic [15:0] mpc, m_val;
    int          m_cost;

    function automatic logic [15:0] mrd(input logic [15:0] a, input logic b);
        logic [15:0] w;
        w = mm[a[10:1]];
        if (!b) return w;
        return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic mwr(input logic [15:0] a, input logic b, input logic [15:0] v);
        if (!b)        mm[a[10:1]] = v;
        else if (a[0]) mm[a[10:1]][15:8] = v[7:0];
        else           mm[a[10:1]][7:0] = v[7:0];
    endtask

    task automatic msrc(input logic [3:0] r, input logic [1:0] m, input logic b);
        logic [15:0] ext, base;
        m_cost = 0;
        if (r == 4'd3) begin
            m_val = (m == 2'd3) ? 16'hFFFF : {14'h0, m};
        end else if (r == 4'd2 && m[1]) begin
            m_val = m[0] ? 16'd8 : 16'd4;
        end else begin
            case (m)
                2'd0: m_val = (r == 4'd0) ? mpc : mr[r];
                2'd1: begin
                    ext  = mm[mpc[10:1]];
                    base = (r == 4'd0) ? mpc : (r == 4'd2) ? 16'h0 : mr[r];
                    mpc  = mpc + 16'd2;
                    m_val = mrd(base + ext, b);
                    m_cost = 2;
                end
                2'd2: begin
                    m_val = mrd((r == 4'd0) ? mpc : mr[r], b);
                    m_cost = 1;
                end
                default: begin
                    if (r == 4'd0) begin
                        m_val = mrd(mpc, b);
                        mpc = mpc + 16'd2;
                    end else begin
                        m_val = mrd(mr[r], b);
                        mr[r] = mr[r] + ((b && r != 4'd1) ? 16'd1 : 16'd2);
                    end
                    m_cost = 1;
                end
            endcase
        end
    endtask

    task automatic mstep(output int cyc, output string tag);
        logic [15:0] w, ext, base, ea, dv, res;
        w = mm[mpc[10:1]];
        mpc = mpc + 16'd2;
        if (w[15:13] == 3'b001) begin
            mpc = mpc + {{5{w[9]}}, w[9:0], 1'b0};
            cyc = 2; tag = "R9";
        end else if (w[15:7] == 9'b000100100) begin
            msrc(w[3:0], w[5:4], w[6]);
            mr[1] = mr[1] - 16'd2;
            mwr(mr[1], w[6], m_val);
            cyc = 2 + m_cost; tag = "R8";
        end else begin
            msrc(w[11:8], w[5:4], w[6]);
            cyc = 1 + m_cost;
            tag = (m_cost == 2) ? "R4" : (m_cost == 1) ? "R3" : "R2";
            if (w[7]) begin
                ext  = mm[mpc[10:1]];
                base = (w[3:0] == 4'd0) ? mpc : (w[3:0] == 4'd2) ? 16'h0 : mr[w[3:0]];
                mpc  = mpc + 16'd2;
                ea   = base + ext;
                dv   = mrd(ea, w[6]);
            end else begin
                ea = 16'h0;
                dv = mr[w[3:0]];
            end
            res = (w[15:12] == 4'h5) ? m_val + dv : m_val;
            if (w[6]) res = {8'h00, res[7:0]};
            if (w[7]) begin
                mwr(ea, w[6], res);
                cyc = cyc + 3;
                tag = (m_cost == 2) ? "R6" : "R5";
            end else begin
                mr[w[3:0]] = res;
            end
            if (w[6]) tag = "R7";
        end
    endtask

    // ---------------- program builder ----------------
    logic [15:0] gp;

    task automatic emit(input logic [15:0] w);
        mem[gp[10:1]] = w;
        mm[gp[10:1]]  = w;
        gp = gp + 16'd2;
    endtask

    task automatic gen_rand();
        int kind, sk, dk;
        logic [3:0] r, d, opc;
        logic [1:0] m;
        logic b, ad;
        logic [15:0] sext, dext;
        kind = $urandom % 16;
        if (kind == 0) begin
            emit(16'h3C01); emit(16'h3FFF); n_instr++;
            return;
        end
        b = 1'($urandom % 2);
        sk = $urandom % 10;
        sext = 16'h0;
        case (sk)
            1: begin r = 4'd3; m = 2'($urandom % 4); end
            2: begin r = 4'd2; m = 2'(2 + $urandom % 2); end
            3: begin r = 4'(4 + $urandom % 4); m = 2'd2; end
            4: begin r = 4'(4 + $urandom % 4); m = 2'd3; end
            5: begin r = 4'd0; m = 2'd3; sext = 16'($urandom); end
            6: begin r = 4'(4 + $urandom % 4); m = 2'd1; sext = 16'($urandom % 32); end
            7: begin r = 4'd2; m = 2'd1; sext = 16'($urandom % 256); end
            8: begin r = 4'd0; m = 2'd1; sext = 16'($urandom % 256); end
            default: begin r = 4'(8 + $urandom % 4); m = 2'd0; end
        endcase
        if (kind <= 2) begin
            emit({9'b000100100, b, m, r});
            ad = 1'b0; dk = 0;
        end else begin
            opc = ($urandom % 2) ? 4'h4 : 4'h5;
            dk = $urandom % 5;
            dext = 16'h0;
            case (dk)
                2: begin d = 4'(4 + $urandom % 4); ad = 1'b1; dext = 16'($urandom % 32); end
                3: begin d = 4'd2; ad = 1'b1; dext = 16'($urandom % 256); end
                4: begin d = 4'd0; ad = 1'b1; dext = 16'($urandom % 256); end
                default: begin d = 4'(8 + $urandom % 4); ad = 1'b0; end
            endcase
            emit({opc, r, ad, b, m, d});
        end
        if (sk >= 5 && sk <= 7) emit(sext);
        else if (sk == 8)       emit(sext - gp);
        if (dk == 2 || dk == 3) emit(dext);
        else if (dk == 4)       emit(dext - gp);
        n_instr++;
    endtask

    initial begin
        int cyc, act_c;
        string tag;
        int bad;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = (i < 128) ? 16'($urandom) : 16'h0000;
            mm[i]  = mem[i];
        end
        for (int i = 0; i < 16; i++) mr[i] = 16'h0;
        mpc = 16'h0100;
        gp  = 16'h0100;
        // register setup via immediate moves (R1, R3 immediate source)
        emit(16'h4031); emit(16'h0100);
        emit(16'h4034); emit(16'h0010);
        emit(16'h4035); emit(16'h0030);
        emit(16'h4036); emit(16'h0050);
        emit(16'h4037); emit(16'h0070);
        for (int k = 8; k < 12; k++) begin
            emit(16'h4030 | 16'(k)); emit(16'($urandom));
        end
        n_instr = 9;
        // directed corners: all six constants (R2)
        emit(16'h5308); emit(16'h5318); emit(16'h5328); emit(16'h5338);
        emit(16'h5229); emit(16'h5239);
        n_instr += 6;
        // byte read from odd absolute address (R7)
        emit(16'h425A); emit(16'h0011);
        // byte push of an immediate (R8)
        emit(16'h1270); emit(16'h00A5);
        // indexed to indexed: source extension first (R6)
        emit(16'h4495); emit(16'h0004); emit(16'h0006);
        // forward jump over a dead word (R9)
        emit(16'h3C01); emit(16'h3FFF);
        // byte auto-increment add (R3)
        emit(16'h567B);
        n_instr += 5;
        for (int k = 0; k < 40; k++) gen_rand();
        // store R1 and R4..R11 to absolute slots (R1)
        emit(16'h4182); emit(16'h00E0);
        for (int k = 4; k < 12; k++) begin
            emit(16'h4082 | (16'(k) << 8)); emit(16'(16'h00E2 + 2 * (k - 4)));
        end
        n_instr += 9;
        emit(16'h3FFF);

        // reset state (R11)
        repeat (3) @(negedge clk);
        chk(mem_addr == 16'h0100, "R11", "fetch address", mem_addr, 16'h0100);
        chk(mem_rd == 1'b1, "R11", "fetch read", mem_rd, 1);
        chk(done == 1'b0 && mem_wr == 1'b0, "R11", "idle outputs", {done, mem_wr}, 0);
        rst_n = 1'b1;

        for (int k = 0; k < n_instr; k++) begin
            while (!timed_out) begin
                @(negedge clk);
                if (done) break;
            end
            if (timed_out) break;
            mstep(cyc, tag);
            act_c = int'(cycles);
            chk(act_c == cyc, {"R10 ", tag}, "cycles", act_c, cyc);
            bad = -1;
            for (int a = 0; a < 128; a++)
                if (bad < 0 && mem[a] !== mm[a]) bad = a;
            if (k >= n_instr - 9)
                chk(bad < 0, {"R1 ", tag}, "store word", (bad < 0) ? 0 : mem[bad],
                    (bad < 0) ? 0 : mm[bad]);
            else
                chk(bad < 0, {"R6 ", tag}, "data word", (bad < 0) ? 0 : mem[bad],
                    (bad < 0) ? 0 : mm[bad]);
        end
        chk(!timed_out, "R10", "watchdog", timed_out, 0);
        chk(n_both == 0, "R12", "read+write cycles", n_both, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule